// File: doc/BRIEF.md
# Data Line Timeout Detector

This block guards the data-line phase of an SD-style host. When the host begins waiting for data-line activity, it pulses `wait_start`. When that activity arrives, it pulses `wait_stop`. If neither a stop nor a restart comes before a programmable number of timeout-clock ticks, the block records a data timeout. The timeout clock itself is produced elsewhere. Here it appears only as the single-cycle qualifier `tick_en`. The block covers only waits on the data lines; command-line waits are handled outside it.

The interval comes from a 4-bit exponent code held in a byte-wide control register. Code n (0 to 14) selects 2^(BASE_EXP+n) ticks; with the default BASE_EXP of 13 that spans 2^13 to 2^27. Code 15 is reserved and is treated as the longest interval. The code is captured when a wait begins, so a rewrite during a wait affects only the next one.

An expiry reaches the sticky `timeout_err` flag only while `stat_en` is high. Otherwise it is discarded. This lets software reprogram the interval with the enable cleared and not see a false error. A data-line software reset returns the detector to rest. The sequencer has three states:
- **IDLE**: at rest.
- **COUNTING**: a wait is in progress.
- **EXPIRED**: the last wait ran out.

It has these transitions:
- IDLE→COUNTING, and also EXPIRED→COUNTING, on start.
- COUNTING→COUNTING on a restart.
- COUNTING→IDLE on stop.
- COUNTING→EXPIRED on reaching the limit.
- EXPIRED→IDLE on stop.
- Any state→IDLE on software reset.

Top module: `dat_timeout_guard`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `reg_rd_data` reads 0 (code 0, the shortest interval), `timeout_err` is 0 and `busy` is 0.
- R2: The interval code occupies bits [3:0] of the control byte. Bits [7:4] always read 0, and writes to them are ignored.
- R3: With latched code n in 0..14, the expiry occurs on the tick that brings the tick count since the last start to 2^(BASE_EXP+n). The flag is visible after the edge of that tick, and never before.
- R4: The reserved code 15 gives the same interval as code 14 and never a shorter one.
- R5: Only cycles with `tick_en` high advance the count. Cycles with `tick_en` low do not bring the expiry closer.
- R6: A `wait_stop` pulse ends the wait (`busy` goes 0) and clears the count. No expiry follows from that wait.
- R7: A `wait_start` during a wait restarts the count from zero.
- R8: An expiry occurring while `stat_en` is 0 is dropped. Setting `stat_en` afterwards does not raise the flag.
- R9: `timeout_err` stays set until a cycle with `stat_clr` high, and it reads 0 after that edge. If an expiry and `stat_clr` fall in the same cycle, the set wins.
- R10: A control write during a wait does not change that wait's interval. The new code applies from the next `wait_start`.
- R11: A `dat_sw_rst` pulse clears the count, the wait, and `timeout_err`.
- R12: `busy` is 1 in COUNTING only. It drops on the same edge at which an expiry is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Timeout clock qualifier, one tick per high cycle |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write data |
| reg_rd_data | output | 8 | Control register read data |
| wait_start | input | 1 | Start or restart a data-line wait |
| wait_stop | input | 1 | Awaited data-line activity arrived |
| dat_sw_rst | input | 1 | Data-line software reset pulse |
| stat_en | input | 1 | Data timeout status enable |
| stat_clr | input | 1 | Write-one-to-clear for the timeout flag |
| busy | output | 1 | A wait is being timed |
| timeout_err | output | 1 | Sticky data timeout status flag |

## Verification
The assertions assume that every control input is a clean level sampled at the rising edge. They also assume that `wait_start` and `wait_stop` are never raised in the same cycle as a control write that the current wait should ignore. The bench drives every input only on falling edges. It keeps start, stop, write and clear strobes one cycle wide and never overlaps them. The bench instantiates the block with a small BASE_EXP, so that even the reserved-code interval completes within the run. The code-to-exponent offset is unchanged.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int CODE_W   = 4;
    localparam int REG_W    = 8;
    localparam int MAX_STEP = 14;
    localparam logic [CODE_W-1:0] RESERVED_CODE = '1;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COUNTING = 2'd1,
        ST_EXPIRED  = 2'd2
    } dtg_state_e;

    // Exponent step above the base for a given code; reserved maps to the top
    function automatic int step_of(input logic [CODE_W-1:0] code);
        if (code == RESERVED_CODE) return MAX_STEP;
        return int'(code);
    endfunction

endpackage

// File: rtl/dtg_ctrl_reg.sv
module dtg_ctrl_reg
    import dtg_pkg::*;
#(
    parameter int DATA_W  = REG_W,
    parameter int FIELD_W = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [FIELD_W-1:0] code
);

    localparam int PAD_W = DATA_W - FIELD_W;

    logic [FIELD_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (wr_en) begin
            code_q <= wr_data[FIELD_W-1:0];
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, code_q};
        end else begin : g_nopad
            assign rd_data = code_q;
        end
    endgenerate

    assign code = code_q;

endmodule

// File: rtl/dtg_interval_cnt.sv
module dtg_interval_cnt
    import dtg_pkg::*;
#(
    parameter int BASE_EXP = 13,
    parameter int CNT_W    = BASE_EXP + MAX_STEP + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    input  logic              run,
    input  logic              tick_en,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CODE_W-1:0] code_o,
    output logic              hit_o
);

    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  limit_m1;
    int                shift;

    always_comb begin
        shift    = BASE_EXP + step_of(code_q);
        limit_m1 = (CNT_W'(1) << shift) - CNT_W'(1);
    end

    assign hit_o = run && tick_en && (cnt_q == limit_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= '0;
        end else begin
            if (load) begin
                code_q <= code_in;
            end
            if (clr) begin
                cnt_q <= '0;
            end else if (run && tick_en && !hit_o) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign code_o = code_q;

endmodule

// File: rtl/dtg_seq_fsm.sv
module dtg_seq_fsm
    import dtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic       sw_rst,
    input  logic       hit,
    output dtg_state_e state_o,
    output logic       cnt_clr,
    output logic       code_load,
    output logic       cnt_run,
    output logic       busy,
    output logic       expire_evt
);

    dtg_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection; software reset outranks start, start outranks stop
    always_comb begin
        state_d = state_q;
        if (sw_rst) begin
            state_d = ST_IDLE;
        end else if (start) begin
            state_d = ST_COUNTING;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_COUNTING: begin
                    if (stop)     state_d = ST_IDLE;
                    else if (hit) state_d = ST_EXPIRED;
                end
                ST_EXPIRED:  if (stop) state_d = ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cnt_clr    = start || stop || sw_rst;
        code_load  = start && !sw_rst;
        cnt_run    = 1'b0;
        busy       = 1'b0;
        expire_evt = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_COUNTING: begin
                cnt_run    = 1'b1;
                busy       = 1'b1;
                expire_evt = hit && !start && !stop && !sw_rst;
            end
            ST_EXPIRED:  ;
            default:     ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/dat_timeout_guard.sv
module dat_timeout_guard
    import dtg_pkg::*;
#(
    parameter int BASE_EXP = 13,
    parameter int DATA_W   = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              wait_start,
    input  logic              wait_stop,
    input  logic              dat_sw_rst,
    input  logic              stat_en,
    input  logic              stat_clr,
    output logic              busy,
    output logic              timeout_err
);

    localparam int CNT_W = BASE_EXP + MAX_STEP + 1;

    logic [CODE_W-1:0] reg_code;
    logic [CODE_W-1:0] code_lat;
    logic [CNT_W-1:0]  cnt;
    logic              hit;
    logic              cnt_clr;
    logic              code_load;
    logic              cnt_run;
    logic              expire_evt;
    logic              err_q;
    dtg_state_e        state;

    dtg_ctrl_reg #(
        .DATA_W  (DATA_W),
        .FIELD_W (CODE_W)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .code    (reg_code)
    );

    dtg_interval_cnt #(
        .BASE_EXP (BASE_EXP),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .load    (code_load),
        .code_in (reg_code),
        .run     (cnt_run),
        .tick_en (tick_en),
        .cnt_o   (cnt),
        .code_o  (code_lat),
        .hit_o   (hit)
    );

    dtg_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (wait_start),
        .stop       (wait_stop),
        .sw_rst     (dat_sw_rst),
        .hit        (hit),
        .state_o    (state),
        .cnt_clr    (cnt_clr),
        .code_load  (code_load),
        .cnt_run    (cnt_run),
        .busy       (busy),
        .expire_evt (expire_evt)
    );

    // Sticky status flag: masked set, write-one clear, set wins a tie
    always_ff @(posedge clk) begin
        if (!rst_n || dat_sw_rst) begin
            err_q <= 1'b0;
        end else if (expire_evt && stat_en) begin
            err_q <= 1'b1;
        end else if (stat_clr) begin
            err_q <= 1'b0;
        end
    end

    assign timeout_err = err_q;

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
#(
    parameter int BASE_EXP = 13,
    parameter int DATA_W   = REG_W,
    parameter int CNT_W    = BASE_EXP + MAX_STEP + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              reg_wr_en,
    input logic [DATA_W-1:0] reg_rd_data,
    input logic              wait_start,
    input logic              wait_stop,
    input logic              dat_sw_rst,
    input logic              stat_en,
    input logic              stat_clr,
    input logic              busy,
    input logic              timeout_err,
    input logic [CNT_W-1:0]  cnt,
    input logic [CODE_W-1:0] code_lat
);

    logic [CNT_W-1:0] chk_limit;
    always_comb begin
        chk_limit = CNT_W'(1) << (BASE_EXP + ((code_lat == RESERVED_CODE) ? MAX_STEP : int'(code_lat)));
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_rd_data == '0 && !timeout_err && !busy));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[DATA_W-1:CODE_W] == '0);

    assert_cnt_below_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < chk_limit);

    assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wait_start && !wait_stop && !dat_sw_rst) |=> $stable(cnt));

    assert_stop_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_stop && !wait_start) |=> !busy);

    assert_masked_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> $past(stat_en));

    assert_sticky_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && !stat_clr && !dat_sw_rst) |=> timeout_err);

    assert_code_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wait_start) |=> $stable(code_lat));

    assert_swrst_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dat_sw_rst |=> (!busy && !timeout_err && cnt == '0));

    assert_busy_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> !busy);

endmodule

bind dat_timeout_guard dtg_checker #(
    .BASE_EXP (BASE_EXP),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W)
) u_dtg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_data (reg_rd_data),
    .wait_start  (wait_start),
    .wait_stop   (wait_stop),
    .dat_sw_rst  (dat_sw_rst),
    .stat_en     (stat_en),
    .stat_clr    (stat_clr),
    .busy        (busy),
    .timeout_err (timeout_err),
    .cnt         (cnt),
    .code_lat    (code_lat)
);

// File: tb/test_dat_timeout_guard.sv
`timescale 1ns/1ps
module test_dat_timeout_guard;

    localparam int BASE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] reg_rd_data;
    logic       wait_start = 1'b0;
    logic       wait_stop = 1'b0;
    logic       dat_sw_rst = 1'b0;
    logic       stat_en = 1'b1;
    logic       stat_clr = 1'b0;
    logic       busy;
    logic       timeout_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dat_timeout_guard #(.BASE_EXP(BASE)) i_dat_timeout_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .wait_start  (wait_start),
        .wait_stop   (wait_stop),
        .dat_sw_rst  (dat_sw_rst),
        .stat_en     (stat_en),
        .stat_clr    (stat_clr),
        .busy        (busy),
        .timeout_err (timeout_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = v;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); wait_start = 1'b1;
        @(negedge clk); wait_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); wait_stop = 1'b1;
        @(negedge clk); wait_stop = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    task automatic pulse_swrst();
        @(negedge clk); dat_sw_rst = 1'b1;
        @(negedge clk); dat_sw_rst = 1'b0;
    endtask

    function automatic int lim(input int code);
        return 1 << (BASE + ((code == 15) ? 14 : code));
    endfunction

    task automatic t_reset();
        check("R1 reg", int'(reg_rd_data), 0);
        check("R1 err", int'(timeout_err), 0);
        check("R1 busy", int'(busy), 0);
    endtask

    task automatic t_register();
        write_reg(8'hF5);
        check("R2 upper ignored", int'(reg_rd_data), 5);
        write_reg(8'hA3);
        check("R2 field", int'(reg_rd_data), 3);
    endtask

    task automatic t_interval(input int code, input string req);
        pulse_swrst();
        write_reg(8'(code));
        pulse_start();
        step(lim(code) - 1);
        check({req, " early"}, int'(timeout_err), 0);
        check({req, " busy"}, int'(busy), 1);
        step(1);
        check({req, " expiry"}, int'(timeout_err), 1);
        check("R12 busy drop", int'(busy), 0);
    endtask

    task automatic t_tick_gate();
        pulse_swrst();
        write_reg(8'd1);
        tick_en = 1'b0;
        pulse_start();
        step(20);
        check("R5 no ticks", int'(timeout_err), 0);
        tick_en = 1'b1;
        step(lim(1) - 1);
        tick_en = 1'b0;
        step(6);
        check("R5 gated", int'(timeout_err), 0);
        tick_en = 1'b1;
        step(1);
        check("R5 last tick", int'(timeout_err), 1);
    endtask

    task automatic t_stop();
        pulse_swrst();
        write_reg(8'd0);
        pulse_start();
        step(2);
        pulse_stop();
        check("R6 busy", int'(busy), 0);
        step(20);
        check("R6 no expiry", int'(timeout_err), 0);
    endtask

    task automatic t_restart();
        pulse_swrst();
        write_reg(8'd1);
        pulse_start();
        step(5);
        pulse_start();
        step(lim(1) - 1);
        check("R7 restarted", int'(timeout_err), 0);
        step(1);
        check("R7 expiry", int'(timeout_err), 1);
    endtask

    task automatic t_mask();
        pulse_swrst();
        write_reg(8'd0);
        stat_en = 1'b0;
        pulse_start();
        step(10);
        check("R8 masked", int'(timeout_err), 0);
        stat_en = 1'b1;
        step(5);
        check("R8 dropped", int'(timeout_err), 0);
    endtask

    task automatic t_clear();
        pulse_swrst();
        write_reg(8'd0);
        pulse_start();
        step(10);
        check("R9 set", int'(timeout_err), 1);
        step(10);
        check("R9 sticky", int'(timeout_err), 1);
        pulse_clr();
        check("R9 cleared", int'(timeout_err), 0);
    endtask

    task automatic t_deferred();
        pulse_swrst();
        write_reg(8'd1);
        pulse_start();
        write_reg(8'd0);
        step(lim(1) - 3);
        check("R10 old code kept", int'(timeout_err), 0);
        step(1);
        check("R10 old expiry", int'(timeout_err), 1);
        pulse_clr();
        pulse_start();
        step(lim(0) - 1);
        check("R10 new early", int'(timeout_err), 0);
        step(1);
        check("R10 new code", int'(timeout_err), 1);
    endtask

    task automatic t_swrst();
        pulse_swrst();
        write_reg(8'd0);
        pulse_start();
        step(10);
        check("R11 pre-set", int'(timeout_err), 1);
        write_reg(8'd1);
        pulse_start();
        step(2);
        pulse_swrst();
        check("R11 err", int'(timeout_err), 0);
        check("R11 busy", int'(busy), 0);
        step(20);
        check("R11 stays quiet", int'(timeout_err), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_register();
        t_interval(0, "R3 code0");
        t_interval(1, "R3 code1");
        t_interval(3, "R3 code3");
        t_interval(5, "R3 code5");
        t_interval(15, "R4 reserved");
        t_tick_gate();
        t_stop();
        t_restart();
        t_mask();
        t_clear();
        t_deferred();
        t_swrst();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule